// File: doc/BRIEF.md
# Deductive Frame Boundary Aligner

This block sits behind a bit-sampling front end. It receives one recovered bit per enabled clock and finds where each 12-bit frame begins. Every frame carries a start bit of 1, ten data bits and an end bit of 0. The end-to-start boundary is therefore the one bit position that shows a 0-to-1 transition in every frame. The aligner needs no fixed comma word to find it. It holds a mask of candidate positions and removes each position as soon as a frame passes without a rising edge there. A lone survivor becomes the presumed boundary. That boundary must then show two consecutive rising edges before lock is declared.

Once locked, the block outputs each frame's ten data bits as a parallel word, together with a one-cycle strobe. It keeps checking for the boundary edge on every frame. A single missing edge drops lock, raises a one-cycle loss pulse and starts the search again. A synchronous restart input forces a new search at any time. A bit-enable input marks the cycles that carry a bit, so the block can run on a fast clock with sparse bits.

Top module: `frame_aligner`

## Requirements
- R1: After reset is released, `locked`, `word_vld` and `lost` are all 0.
- R2: A frame is 12 bits in arrival order: a start bit of 1, data bits 0 to 9, then an end bit of 0. The boundary is the 0-to-1 step from an end bit to the following start bit.
- R3: A candidate position is eliminated when its bit arrives without a rising edge. Lock can only follow when one candidate remains, so a stream with a second rising edge at a fixed data position in every frame (data bit 2 = 0, data bit 3 = 1) never locks.
- R4: Sync frames (data word 10'h01F, which gives six ones then six zeros per frame) bring the block to lock within 42 frames of a restart, at any bit offset.
- R5: Lock is declared only after the surviving position has shown two consecutive rising edges. This applies to the first lock and to every relock after a loss. `locked` rises in the cycle after the clock edge that samples the second such start bit.
- R6: `word_out` bit 0 is the first data bit after the start bit. `word_vld` is high for exactly one cycle per frame, in the cycle after the edge that samples data bit 9, and only in frames whose start bit was sampled while locked.
- R7: While locked, a start-bit position that arrives without a rising edge causes `locked` to fall and `lost` to pulse for one cycle. Both appear in the cycle after the edge that samples that bit.
- R8: If every candidate is eliminated, the mask returns to all 12 positions. A long edge-free stream followed by sync frames therefore still locks within 42 frames.
- R9: A cycle with `bit_en` low has no effect: neither the frame phase, the candidates, lock nor the words change, whatever `bit_in` is.
- R10: `restart` is synchronous. It drops `locked` in the next cycle and begins a fresh search with all candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart | input | 1 | Synchronous search restart |
| bit_en | input | 1 | High when `bit_in` carries a valid bit |
| bit_in | input | 1 | Recovered serial bit |
| word_out | output | DATA_W (10) | Last extracted data word, bit 0 received first |
| word_vld | output | 1 | One-cycle strobe per frame while locked |
| locked | output | 1 | Frame alignment held |
| lost | output | 1 | One-cycle pulse on loss of alignment |

## Verification
Every result is due in the cycle after the clock edge that samples the bit causing it. The bench drives each bit one time unit after an edge, then samples all outputs one time unit after the next edge, where the registers have just updated. The lock state is read after each start bit. That reading sets whether the strobe must appear after data bit 9 of the same frame, and on every other bit the strobe is checked to be low. Loss is checked right after the bad start bit and again one bit later, so the pulse is confirmed to last exactly one cycle.

// File: rtl/frame_aligner_pkg.sv
package frame_aligner_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } align_st_e;
endpackage

// File: rtl/fa_phase.sv
// Frame phase counter and rising-edge detector on the incoming bit.
module fa_phase #(
  parameter int FRAME_LEN = 12,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            bit_in,
  output logic [PH_W-1:0] ph,
  output logic            rise
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic            prev_q, prev_d;

  always_comb begin
    ph_d   = ph_q;
    prev_d = prev_q;
    if (step) begin
      ph_d   = (ph_q == PH_W'(FRAME_LEN - 1)) ? '0 : ph_q + 1'b1;
      prev_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      prev_q <= prev_d;
    end
  end

  assign ph   = ph_q;
  assign rise = step & bit_in & ~prev_q;

  // R2: phase never leaves the frame
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PH_W'(FRAME_LEN));
  // R9: a cycle without a bit leaves the phase alone
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ph_q));
endmodule

// File: rtl/fa_cand.sv
// Candidate mask: positions are cleared when their bit shows no rising edge.
module fa_cand #(
  parameter int FRAME_LEN = 12,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 clear,
  input  logic [PH_W-1:0]      ph,
  input  logic                 rise,
  output logic [FRAME_LEN-1:0] mask,
  output logic                 single,
  output logic [PH_W-1:0]      sel
);
  logic [FRAME_LEN-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (step && !rise) begin
      for (int i = 0; i < FRAME_LEN; i++) begin
        if (ph == PH_W'(i)) mask_d[i] = 1'b0;
      end
    end
    if (mask_d == '0) mask_d = '1;
    if (clear) mask_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  always_comb begin
    sel = '0;
    for (int i = FRAME_LEN - 1; i >= 0; i--) begin
      if (mask_q[i]) sel = PH_W'(i);
    end
  end

  assign mask   = mask_q;
  assign single = (mask_q != '0) && ((mask_q & (mask_q - 1'b1)) == '0);

  // R8: an empty mask is never held
  p_mask_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '0);
  // R10: a clear always reopens every position
  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask_q == '1));
endmodule

// File: rtl/fa_word.sv
// Serial-to-parallel word capture, first data bit lands in bit 0.
module fa_word #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              bit_in,
  input  logic              emit,
  output logic [DATA_W-1:0] word,
  output logic              vld
);
  logic [DATA_W-1:0] sr_q, sr_d, word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    sr_d   = sr_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (step) sr_d = {bit_in, sr_q[DATA_W-1:1]};
    if (step && emit) begin
      word_d = sr_d;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word = word_q;
  assign vld  = vld_q;

  // R6: strobes never come back to back
  p_vld_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R6: the word only moves with a strobe
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(word_q));
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import frame_aligner_pkg::*;
#(
  parameter int DATA_W        = 10,
  parameter int CONFIRM_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld,
  output logic              locked,
  output logic              lost
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int PH_W      = $clog2(FRAME_LEN);
  localparam int HIT_W     = $clog2(CONFIRM_EDGES + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sr_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_s_n = rst_sr_q[1];

  logic [PH_W-1:0]      ph, cand_sel, bpos_q, bpos_d, emit_ph;
  logic                 rise, cand_single, drop, cand_step, cand_clear, emit;
  logic [FRAME_LEN-1:0] cand_mask;
  logic [PH_W:0]        emit_sum;
  logic [HIT_W-1:0]     hits_q, hits_d;
  logic                 lost_q, lost_d;
  align_st_e            st_q, st_d;

  fa_phase #(.FRAME_LEN(FRAME_LEN)) u_phase (
    .clk(clk), .rst_n(rst_s_n), .step(bit_en), .bit_in(bit_in),
    .ph(ph), .rise(rise)
  );

  assign cand_step  = bit_en && (st_q != ST_LOCKED);
  assign cand_clear = restart || drop;

  fa_cand #(.FRAME_LEN(FRAME_LEN)) u_cand (
    .clk(clk), .rst_n(rst_s_n), .step(cand_step), .clear(cand_clear),
    .ph(ph), .rise(rise), .mask(cand_mask), .single(cand_single), .sel(cand_sel)
  );

  // last data bit sits DATA_W positions after the start bit
  always_comb begin
    emit_sum = {1'b0, bpos_q} + (PH_W+1)'(DATA_W);
    if (emit_sum >= (PH_W+1)'(FRAME_LEN)) emit_sum = emit_sum - (PH_W+1)'(FRAME_LEN);
    emit_ph = emit_sum[PH_W-1:0];
  end
  assign emit = (st_q == ST_LOCKED) && (ph == emit_ph);

  fa_word #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_s_n), .step(bit_en), .bit_in(bit_in),
    .emit(emit), .word(word_out), .vld(word_vld)
  );

  always_comb begin
    st_d   = st_q;
    bpos_d = bpos_q;
    hits_d = hits_q;
    lost_d = 1'b0;
    drop   = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (cand_single) begin
          st_d   = ST_CONFIRM;
          bpos_d = cand_sel;
          hits_d = '0;
        end
      end
      ST_CONFIRM: begin
        if (!cand_single) begin
          st_d = ST_SEARCH;
        end else if (bit_en && (ph == bpos_q)) begin
          if (!rise)                                    st_d   = ST_SEARCH;
          else if (hits_q == HIT_W'(CONFIRM_EDGES - 1)) st_d   = ST_LOCKED;
          else                                          hits_d = hits_q + 1'b1;
        end
      end
      ST_LOCKED: begin
        if (bit_en && (ph == bpos_q) && !rise) begin
          st_d   = ST_SEARCH;
          lost_d = 1'b1;
          drop   = 1'b1;
        end
      end
      default: st_d = ST_SEARCH;
    endcase
    if (restart) begin
      st_d   = ST_SEARCH;
      lost_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_SEARCH;
      bpos_q <= '0;
      hits_q <= '0;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bpos_q <= bpos_d;
      hits_q <= hits_d;
      lost_q <= lost_d;
    end
  end

  assign locked = (st_q == ST_LOCKED);
  assign lost   = lost_q;

  // R6: a strobe is only produced from the locked state
  p_vld_locked_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    word_vld |-> $past(locked));
  // R7: loss pulse follows a locked cycle and leaves lock dropped
  p_lost_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    lost |-> (!locked && $past(locked)));
  // R7: loss is a single-cycle pulse
  p_lost_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    lost |=> !lost);
  // R5: lock is only entered on a confirming edge
  p_lock_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(locked) |-> ($past(rise) && $past(st_q == ST_CONFIRM)));
  // R10: restart removes lock on the next cycle
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    restart |=> !locked);
  // R3: candidate set is down to one while confirming or locked
  p_single_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    locked |-> $onehot0(cand_mask));
endmodule

// File: tb/frame_aligner_bench.sv
`timescale 1ns/1ps
module frame_aligner_bench;
  localparam logic [9:0] SYNC_W = 10'h01F;

  logic       clk = 1'b0;
  logic       rst_n, restart, bit_en, bit_in;
  logic [9:0] word_out;
  logic       word_vld, locked, lost;

  int errors = 0;
  int checks = 0;
  int vld_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  frame_aligner u_frame_aligner (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bit_en(bit_en), .bit_in(bit_in),
    .word_out(word_out), .word_vld(word_vld), .locked(locked), .lost(lost)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] rnd10();
    logic [9:0] r;
    for (int k = 0; k < 10; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r[k] = lfsr[0];
    end
    return r;
  endfunction

  // one cycle, sampled one unit after the edge that used the inputs
  task automatic drive(input logic b, input logic e);
    bit_en  = e;
    bit_in  = b;
    restart = 1'b0;
    @(posedge clk);
    #1;
    if (word_vld) vld_cnt++;
  endtask

  task automatic do_restart();
    bit_en  = 1'b0;
    restart = 1'b1;
    @(posedge clk);
    #1;
    restart = 1'b0;
    chk(!locked, "R10 restart drops lock", locked, 0);
  endtask

  // sb: start bit value; gaps: insert idle cycles with garbage data
  task automatic send_frame(input logic [9:0] d, input bit gaps, input logic sb);
    logic lk, lk_before, b;
    lk = 1'b0;
    lk_before = locked;
    for (int i = 0; i < 12; i++) begin
      if (gaps && (i % 3 == 1)) begin
        drive(lfsr[3], 1'b0);
        drive(~lfsr[5], 1'b0);
      end
      b = (i == 0) ? sb : (i == 11) ? 1'b0 : d[i-1];
      drive(b, 1'b1);
      if (i == 0) begin
        lk = locked;
        if (!sb && lk_before) begin
          chk(lost, "R7 lost pulse", lost, 1);
          chk(!locked, "R7 lock dropped", locked, 0);
        end
      end
      if (i == 1 && !sb && lk_before) chk(!lost, "R7 pulse one cycle", lost, 0);
      chk(word_vld == ((i == 10) && lk), "R6 strobe timing", word_vld, (i == 10) && lk);
      if (i == 10 && lk) chk(word_out == d, "R6 R2 word content", word_out, d);
    end
  endtask

  // send sync frames until lock, returns frames used
  task automatic lock_on_sync(input int limit, output int nfr);
    nfr = 0;
    while (!locked && nfr < limit) begin
      send_frame(SYNC_W, 1'b0, 1'b1);
      nfr++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nfr, v0;
    logic [9:0] d;
    rst_n = 1'b0; restart = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!locked && !word_vld && !lost, "R1 reset state", {locked, word_vld, lost}, 0);

    // sync frames at every bit offset
    for (int k = 0; k < 12; k++) begin
      do_restart();
      for (int f = 0; f < k; f++) drive(1'b0, 1'b1);
      lock_on_sync(42, nfr);
      chk(locked, "R4 sync lock within 42 frames", nfr, 42);
      chk(nfr >= 2, "R5 two boundary edges before lock", nfr, 2);
      v0 = vld_cnt;
      send_frame(SYNC_W, 1'b0, 1'b1);
      send_frame(SYNC_W, 1'b0, 1'b1);
      chk(vld_cnt - v0 == 2, "R6 one strobe per frame", vld_cnt - v0, 2);
    end

    // random data lock
    do_restart();
    nfr = 0;
    while (!locked && nfr < 60) begin
      send_frame(rnd10(), 1'b0, 1'b1);
      nfr++;
    end
    chk(locked, "R3 random data lock", nfr, 60);
    for (int f = 0; f < 4; f++) send_frame(rnd10(), 1'b0, 1'b1);

    // idle cycles in between bits do nothing
    v0 = vld_cnt;
    for (int f = 0; f < 6; f++) send_frame(rnd10(), 1'b1, 1'b1);
    chk(locked, "R9 lock held across idle cycles", locked, 1);
    chk(vld_cnt - v0 == 6, "R9 words across idle cycles", vld_cnt - v0, 6);

    // missing boundary edge, then relock
    send_frame(rnd10(), 1'b0, 1'b0);
    nfr = 0;
    while (!locked && nfr < 60) begin
      send_frame(rnd10(), 1'b0, 1'b1);
      nfr++;
    end
    chk(locked, "R7 relock after loss", nfr, 60);
    chk(nfr >= 2, "R5 relock needs two edges", nfr, 2);

    // second permanent rising edge: never resolves
    do_restart();
    for (int f = 0; f < 40; f++) begin
      d = rnd10();
      d[2] = 1'b0;
      d[3] = 1'b1;
      send_frame(d, 1'b0, 1'b1);
      if (f % 8 == 7) chk(!locked, "R3 ambiguous stream stays unlocked", locked, 0);
    end

    // edge-free stream empties the mask, then sync still locks
    do_restart();
    for (int i = 0; i < 360; i++) drive(1'b0, 1'b1);
    chk(!locked, "R8 no lock on flat stream", locked, 0);
    lock_on_sync(42, nfr);
    chk(locked, "R8 lock after emptied mask", nfr, 42);
    send_frame(SYNC_W, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule